// File: doc/BRIEF.md
# Critical-Word-First Line Fill Sequencer

This block sits between a processor load port and an external burst bus. A load that misses the local line buffer becomes a four-beat line fill. Each beat is one 64-bit word. The bus delivers the word the load asked for on the first beat, and the processor gets that word back as soon as the beat lands. The other three words follow in ascending index order, wrapping at the end of the line. They are written into a single-line buffer. Once the fill is complete, later loads to that line are answered from the buffer in one cycle, with no bus traffic.

While a fill is in progress, the block can hold one more load. If the held load belongs to a different line, its own fill is requested on the bus in the cycle right after the current fill's last beat. If it belongs to the line being filled, it waits for the whole fill to finish, then waits a further fixed number of cycles (`PENALTY_CYCLES`, at least 1). Only then is its word returned from the buffer. While a load is held, the load port deasserts ready.

Top module: `lfb_top`

## Requirements
- R1: After reset, `cpu_rsp_valid` and `bus_req` are 0 and `cpu_req_ready` is 1.
- R2: A load accepted while idle whose line is not in the buffer raises `bus_req` in the next cycle. `bus_line` equals address bits [31:5] and `bus_crit_idx` equals address bits [4:3]. Both are held stable, with `bus_req` high, until a cycle in which `bus_gnt` is 1.
- R3: The first beat of a fill is returned on `cpu_rsp_data`, with `cpu_rsp_valid` high for one cycle, in the cycle after that beat is sampled.
- R4: Beat n (n = 0..3) of a fill carries word index (critical index + n) mod 4. Each beat is stored at its own index in the line buffer.
- R5: After a fill completes, an idle load to any word of that line is answered in the cycle after acceptance, with the stored word, and `bus_req` stays 0.
- R6: If a load to a different line is held when the last beat arrives, `bus_req` is high in the next cycle. It carries the held load's line and word index.
- R7: If a load to the line being filled is held when the last beat arrives, `cpu_rsp_valid` stays 0 for exactly `PENALTY_CYCLES` cycles after that beat. The word is then returned from the buffer, and no new fill is requested.
- R8: While a load is held during a fill, and throughout the penalty wait, `cpu_req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Load request valid |
| cpu_req_ready | output | 1 | Load request can be accepted |
| cpu_req_addr | input | 32 | Load byte address |
| cpu_rsp_valid | output | 1 | Returned word valid (one-cycle pulse) |
| cpu_rsp_data | output | 64 | Returned word |
| bus_req | output | 1 | Fill request to the bus |
| bus_gnt | input | 1 | Bus accepts the fill request |
| bus_line | output | 27 | Line address of the requested fill |
| bus_crit_idx | output | 2 | Word index to deliver first |
| bus_beat_valid | input | 1 | Fill beat valid |
| bus_beat_idx | input | 2 | Word index of the beat |
| bus_beat_data | input | 64 | Beat data |

## Verification
The hardest situations to reach are the two overlap cases, because each needs a second load to arrive in the middle of a fill. The stimulus presents that load in the same cycle as the second beat, first with a different line and then with the fill's own line. It then counts cycles from the last beat. For a different line, it looks for an immediate new request. For the same line, it checks for silence through the whole penalty window and for the word arriving exactly after it.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 64;
    localparam int unsigned WORDS  = 4;
    localparam int unsigned WIDX_W = $clog2(WORDS);
    localparam int unsigned OFF_W  = $clog2(DATA_W / 8);
    localparam int unsigned LINE_W = ADDR_W - WIDX_W - OFF_W;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WIDX_W-1:0] widx_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_BURST,
        ST_PEN
    } fill_st_e;

    typedef struct packed {
        line_t line;
        widx_t widx;
    } load_t;

    function automatic load_t split_addr(input addr_t a);
        load_t l;
        l.line = a[ADDR_W-1 -: LINE_W];
        l.widx = a[OFF_W +: WIDX_W];
        return l;
    endfunction

endpackage

// File: rtl/lfb_linebuf.sv
module lfb_linebuf
    import lfb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fill_start,
    input  line_t fill_line,
    input  logic  wr_en,
    input  widx_t wr_idx,
    input  word_t wr_data,
    input  logic  fill_done,
    input  widx_t rd_idx,
    output logic  buf_valid,
    output line_t buf_line,
    output word_t rd_data
);

    word_t words [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_valid <= 1'b0;
            buf_line  <= '0;
        end else if (fill_start) begin
            buf_valid <= 1'b0;
            buf_line  <= fill_line;
        end else if (fill_done) begin
            buf_valid <= 1'b1;
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == widx_t'(w)) begin
                words[w] <= wr_data;
            end
        end
    end

    assign rd_data = words[rd_idx];

    // R4: beats are written only while the line is still being filled
    assert_write_during_fill_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !buf_valid);

    // R5: the buffer becomes usable right after the last beat
    assert_valid_after_done_R5: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> buf_valid);

endmodule

// File: rtl/lfb_ctrl.sv
module lfb_ctrl
    import lfb_pkg::*;
#(
    parameter int unsigned PENALTY_CYCLES = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cpu_valid,
    input  load_t cpu_load,
    output logic  cpu_ready,
    input  logic  buf_hit,
    output logic  bus_req,
    output load_t cur_load,
    input  logic  bus_gnt,
    input  logic  beat_valid,
    input  widx_t beat_idx,
    output logic  fill_start,
    output logic  wr_en,
    output logic  fill_done,
    output logic  rsp_fire,
    output logic  rsp_sel_beat,
    output widx_t rd_idx
);

    localparam int unsigned PEN_W = (PENALTY_CYCLES > 1) ? $clog2(PENALTY_CYCLES) : 1;
    localparam logic [PEN_W-1:0] PEN_LAST = PEN_W'(PENALTY_CYCLES - 1);
    localparam widx_t BEAT_LAST = widx_t'(WORDS - 1);

    fill_st_e         state;
    load_t            pend;
    logic             pend_v;
    widx_t            beat_cnt;
    logic [PEN_W-1:0] pen_cnt;

    logic busy, last_beat, first_beat, accept, idle_hit, pen_end;

    assign busy       = (state == ST_REQ) || (state == ST_BURST);
    assign last_beat  = (state == ST_BURST) && beat_valid && (beat_cnt == BEAT_LAST);
    assign first_beat = (state == ST_BURST) && beat_valid && (beat_cnt == '0);
    assign pen_end    = (state == ST_PEN) && (pen_cnt == PEN_LAST);

    always_comb begin
        unique case (state)
            ST_IDLE:  cpu_ready = 1'b1;
            ST_REQ,
            ST_BURST: cpu_ready = !pend_v && !last_beat;
            default:  cpu_ready = 1'b0;
        endcase
    end

    assign accept   = cpu_valid && cpu_ready;
    assign idle_hit = (state == ST_IDLE) && accept && buf_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_load <= '0;
            pend     <= '0;
            pend_v   <= 1'b0;
            beat_cnt <= '0;
            pen_cnt  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept && !buf_hit) begin
                        cur_load <= cpu_load;
                        state    <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (bus_gnt) begin
                        state    <= ST_BURST;
                        beat_cnt <= '0;
                    end
                    if (accept) begin
                        pend   <= cpu_load;
                        pend_v <= 1'b1;
                    end
                end
                ST_BURST: begin
                    if (accept) begin
                        pend   <= cpu_load;
                        pend_v <= 1'b1;
                    end
                    if (beat_valid) begin
                        beat_cnt <= beat_cnt + widx_t'(1);
                    end
                    if (last_beat) begin
                        if (!pend_v) begin
                            state <= ST_IDLE;
                        end else if (pend.line == cur_load.line) begin
                            state   <= ST_PEN;
                            pen_cnt <= '0;
                        end else begin
                            cur_load <= pend;
                            pend_v   <= 1'b0;
                            state    <= ST_REQ;
                        end
                    end
                end
                default: begin
                    pen_cnt <= pen_cnt + PEN_W'(1);
                    if (pen_end) begin
                        pend_v <= 1'b0;
                        state  <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign bus_req      = (state == ST_REQ);
    assign fill_start   = (state == ST_REQ) && bus_gnt;
    assign wr_en        = (state == ST_BURST) && beat_valid;
    assign fill_done    = last_beat;
    assign rsp_fire     = idle_hit || first_beat || pen_end;
    assign rsp_sel_beat = (state == ST_BURST);
    assign rd_idx       = (state == ST_IDLE) ? cpu_load.widx : pend.widx;

    // R4: beats arrive critical word first, then ascending with wrap
    assert_beat_order_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BURST && beat_valid) |-> beat_idx == widx_t'(cur_load.widx + beat_cnt));

    // R2: an ungranted request keeps its line and index
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> bus_req && $stable(cur_load));

    // R6: a held load to another line is requested with no gap
    assert_back_to_back_R6: assert property (@(posedge clk) disable iff (rst)
        (last_beat && pend_v && pend.line != cur_load.line) |=> bus_req);

    // R8: no second load while one is held during a fill
    assert_one_pending_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && pend_v) |-> !cpu_ready);

    // R7: the penalty wait never issues a bus request
    assert_pen_no_req_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PEN) |-> !bus_req && !cpu_ready);

endmodule

// File: rtl/lfb_top.sv
module lfb_top
    import lfb_pkg::*;
#(
    parameter int unsigned PENALTY_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req_valid,
    output logic        cpu_req_ready,
    input  logic [31:0] cpu_req_addr,
    output logic        cpu_rsp_valid,
    output logic [63:0] cpu_rsp_data,
    output logic        bus_req,
    input  logic        bus_gnt,
    output logic [26:0] bus_line,
    output logic [1:0]  bus_crit_idx,
    input  logic        bus_beat_valid,
    input  logic [1:0]  bus_beat_idx,
    input  logic [63:0] bus_beat_data
);

    load_t cpu_load, cur_load;
    logic  buf_valid, buf_hit;
    line_t buf_line;
    word_t rd_data;
    widx_t rd_idx;
    logic  fill_start, wr_en, fill_done, rsp_fire, rsp_sel_beat;

    assign cpu_load = split_addr(cpu_req_addr);
    assign buf_hit  = buf_valid && (buf_line == cpu_load.line);

    lfb_ctrl #(.PENALTY_CYCLES(PENALTY_CYCLES)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cpu_valid    (cpu_req_valid),
        .cpu_load     (cpu_load),
        .cpu_ready    (cpu_req_ready),
        .buf_hit      (buf_hit),
        .bus_req      (bus_req),
        .cur_load     (cur_load),
        .bus_gnt      (bus_gnt),
        .beat_valid   (bus_beat_valid),
        .beat_idx     (bus_beat_idx),
        .fill_start   (fill_start),
        .wr_en        (wr_en),
        .fill_done    (fill_done),
        .rsp_fire     (rsp_fire),
        .rsp_sel_beat (rsp_sel_beat),
        .rd_idx       (rd_idx)
    );

    lfb_linebuf u_buf (
        .clk        (clk),
        .rst        (rst),
        .fill_start (fill_start),
        .fill_line  (cur_load.line),
        .wr_en      (wr_en),
        .wr_idx     (bus_beat_idx),
        .wr_data    (bus_beat_data),
        .fill_done  (fill_done),
        .rd_idx     (rd_idx),
        .buf_valid  (buf_valid),
        .buf_line   (buf_line),
        .rd_data    (rd_data)
    );

    assign bus_line     = cur_load.line;
    assign bus_crit_idx = cur_load.widx;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rsp_valid <= 1'b0;
            cpu_rsp_data  <= '0;
        end else begin
            cpu_rsp_valid <= rsp_fire;
            if (rsp_fire) begin
                cpu_rsp_data <= rsp_sel_beat ? bus_beat_data : rd_data;
            end
        end
    end

    // R3: the critical beat reaches the load port one cycle later
    assert_crit_return_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_fire && rsp_sel_beat) |=> cpu_rsp_valid && cpu_rsp_data == $past(bus_beat_data));

    // R5: a buffer hit while idle never touches the bus
    assert_hit_no_bus_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_req_ready && buf_hit && !bus_req && !bus_beat_valid) |=> !bus_req);

endmodule

// File: tb/tb_lfb_top.sv
module tb_lfb_top;

    localparam int PEN = 4;
    localparam int NVEC = 6;
    // each entry: {byte address, expected critical index}
    localparam logic [33:0] VEC [NVEC] = '{
        {32'h0000_0000, 2'd0},
        {32'h1234_5678, 2'd3},
        {32'hDEAD_BEE8, 2'd1},
        {32'hFFFF_FFF0, 2'd2},
        {32'h0000_0010, 2'd2},
        {32'h8000_0028, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic [31:0] cpu_req_addr = '0;
    logic        cpu_rsp_valid;
    logic [63:0] cpu_rsp_data;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic [26:0] bus_line;
    logic [1:0]  bus_crit_idx;
    logic        bus_beat_valid = 1'b0;
    logic [1:0]  bus_beat_idx = '0;
    logic [63:0] bus_beat_data = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    lfb_top #(.PENALTY_CYCLES(PEN)) dut (.*);

    function automatic logic [63:0] word_of(input logic [26:0] line, input logic [1:0] idx);
        return {5'd0, line, 30'h155, idx};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a);
        cpu_req_valid = 1'b1;
        cpu_req_addr  = a;
        tick();
        cpu_req_valid = 1'b0;
    endtask

    task automatic grant();
        bus_gnt = 1'b1;
        tick();
        bus_gnt = 1'b0;
    endtask

    // feeds four beats; optionally presents a load alongside beat 1
    task automatic run_burst(input logic [26:0] line, input logic [1:0] crit,
                             input bit inj, input logic [31:0] inj_addr);
        for (int i = 0; i < 4; i++) begin
            bus_beat_valid = 1'b1;
            bus_beat_idx   = crit + 2'(i);
            bus_beat_data  = word_of(line, crit + 2'(i));
            if (inj && i == 1) begin
                cpu_req_valid = 1'b1;
                cpu_req_addr  = inj_addr;
            end
            tick();
            cpu_req_valid = 1'b0;
            if (i == 0) begin
                chk("R3 rsp_valid on critical beat", 64'(cpu_rsp_valid), 64'd1);
                chk("R3 critical word data", cpu_rsp_data, word_of(line, crit));
            end
            if (inj && i == 1) begin
                chk("R8 ready low with held load", 64'(cpu_req_ready), 64'd0);
            end
        end
        bus_beat_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [26:0] la, lb;
        repeat (3) tick();
        rst = 1'b0;
        #1;
        chk("R1 rsp_valid after reset", 64'(cpu_rsp_valid), 64'd0);
        chk("R1 bus_req after reset", 64'(bus_req), 64'd0);
        chk("R1 ready after reset", 64'(cpu_req_ready), 64'd1);

        // table-driven misses, each followed by hits on every word
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] a;
            logic [1:0]  c;
            logic [26:0] ln;
            a  = VEC[v][33:2];
            c  = VEC[v][1:0];
            ln = a[31:5];
            issue(a);
            chk("R2 bus_req after miss", 64'(bus_req), 64'd1);
            chk("R2 line address", 64'(bus_line), 64'(ln));
            chk("R2 critical index", 64'(bus_crit_idx), 64'(c));
            tick();
            chk("R2 request held without grant", 64'(bus_req), 64'd1);
            chk("R2 line held without grant", 64'(bus_line), 64'(ln));
            grant();
            chk("R2 request drops after grant", 64'(bus_req), 64'd0);
            run_burst(ln, c, 1'b0, '0);
            tick();
            for (int k = 0; k < 4; k++) begin
                issue({ln, 2'(k), 3'b0});
                chk("R5 hit rsp_valid", 64'(cpu_rsp_valid), 64'd1);
                chk("R4 stored word by index", cpu_rsp_data, word_of(ln, 2'(k)));
                chk("R5 hit leaves bus idle", 64'(bus_req), 64'd0);
            end
        end

        // different-line load held during a fill
        la = 27'h0AB_CDE;
        lb = 27'h011_223;
        issue({la, 2'd1, 3'b0});
        grant();
        run_burst(la, 2'd1, 1'b1, {lb, 2'd3, 3'b0});
        chk("R6 next request right after last beat", 64'(bus_req), 64'd1);
        chk("R6 next line", 64'(bus_line), 64'(lb));
        chk("R6 next critical index", 64'(bus_crit_idx), 64'd3);
        grant();
        run_burst(lb, 2'd3, 1'b0, '0);
        tick();

        // same-line load held during a fill
        la = 27'h3FF_001;
        issue({la, 2'd2, 3'b0});
        grant();
        run_burst(la, 2'd2, 1'b1, {la, 2'd0, 3'b0});
        chk("R7 no rsp right after last beat", 64'(cpu_rsp_valid), 64'd0);
        chk("R8 ready low in penalty", 64'(cpu_req_ready), 64'd0);
        for (int p = 1; p < PEN; p++) begin
            tick();
            chk("R7 no rsp inside penalty", 64'(cpu_rsp_valid), 64'd0);
            chk("R7 no bus request in penalty", 64'(bus_req), 64'd0);
        end
        tick();
        chk("R7 rsp after penalty", 64'(cpu_rsp_valid), 64'd1);
        chk("R7 rsp data from buffer", cpu_rsp_data, word_of(la, 2'd0));
        chk("R7 no new fill", 64'(bus_req), 64'd0);
        tick();
        chk("R7 ready back after penalty", 64'(cpu_req_ready), 64'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule